// File: doc/BRIEF.md
# Timestamp Aging Purge Engine

This block keeps the age of every entry in a small address table. Each slot holds a valid bit, a key and an 8-bit stamp. Inserting or refreshing a slot records the present value of a free-running "now" counter as that slot's stamp. A second 8-bit counter, the "expiry" counter, names the stamp value that is due for removal.

A tick event advances both counters by one and then starts a sweep. The sweep walks the table one slot per clock and clears every valid slot whose stamp equals the expiry value in force when the sweep began. Ticks come from an asynchronous input pin, which is synchronized and edge-detected and only counts when two enable bits of a configuration byte are set. A processor can also bump either counter on its own. Bumping the expiry counter also starts a sweep, because the value to remove has changed.

A tick that arrives while a sweep is running updates the counters at once and is remembered. A second sweep then follows the first with no idle cycle between them. Key lookup and matching belong to the surrounding logic. This block only supplies slot contents through a read port.

Top module: `stamp_age_purge`

## Requirements
- R1: After a synchronous reset (rstN low for at least two clocks) both counters read 0, busy is 0, the configuration byte reads 0 and every slot reads invalid.
- R2: A write (wrEn high for one clock) to slot wrIdx stores wrKey, sets the slot valid and sets its stamp to the now counter's value at that clock edge. A refresh of a valid slot overwrites its stamp the same way.
- R3: With configuration bits 2 and 3 both set, each rising edge of tickPin advances both counters by exactly one. The change is visible on the third rising clock edge after the pin rises (two synchronizer flops, then the counter register). Holding the pin high causes no further advance.
- R4: A rising edge of tickPin has no effect on the counters or the table unless configuration bits 2 and 3 are both 1. Setting only one of the two bits is not enough.
- R5: A sweep clears exactly the valid slots whose stamp equals the expiry target latched when the sweep began. All other slots keep their valid bit, key and stamp.
- R6: A sweep starts on the same clock edge as the counter update that caused it. It visits one slot per clock, and busy reads 1 for exactly N consecutive cycles.
- R7: A tick during a running sweep advances the counters immediately. A second full sweep then follows the first without a gap, so busy stays high for 2N cycles, and the second sweep uses the newer expiry value.
- R8: bumpNow advances only the now counter and starts no sweep.
- R9: bumpExpiry advances only the expiry counter and starts a sweep.
- R10: Both counters wrap from 255 to 0, and a sweep with expiry value 0 clears slots stamped 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| tickPin | input | 1 | Asynchronous tick request; its rising edge counts |
| cfgWrEn | input | 1 | Load the configuration byte |
| cfgWrData | input | 8 | New configuration byte; bits 2 and 3 together enable tickPin |
| bumpNow | input | 1 | Processor advance of the now counter alone |
| bumpExpiry | input | 1 | Processor advance of the expiry counter alone, starts a sweep |
| wrEn | input | 1 | Insert or refresh a slot |
| wrIdx | input | IDX_W | Slot to write |
| wrKey | input | KEY_W | Key to store |
| rdIdx | input | IDX_W | Slot to read |
| rdValid | output | 1 | Valid bit of slot rdIdx |
| rdKey | output | KEY_W | Key of slot rdIdx |
| rdStamp | output | 8 | Stamp of slot rdIdx |
| cfgQ | output | 8 | Current configuration byte |
| nowTime | output | 8 | Now counter |
| expiryTime | output | 8 | Expiry counter |
| busy | output | 1 | A sweep is in progress |

## Verification
On every cycle the assertions check several things. A tick pulse never lasts two cycles. The sweep index steps by one and a pending tick restarts it at slot 0. The now counter moves only on its strobe and by exactly one. A write leaves the slot valid with the now stamp, and a slot that matches the target during a sweep is cleared on the next edge unless it is written at the same time.

The scenarios in the bench cover what depends on sequence and timing. They show the three-edge latency from the pin and that a pin held high gives a single tick. They show that one enable bit alone is ignored and that a back-to-back sweep lasts exactly 2N cycles. They also show that slots stamped 0 disappear only after the expiry counter wraps.

// File: rtl/stamp_age_pkg.sv
package stamp_age_pkg;
  localparam int STAMP_W    = 8;
  localparam int CFG_W      = 8;
  localparam int GATE_BIT_A = 2;
  localparam int GATE_BIT_B = 3;

  typedef logic [STAMP_W-1:0] stamp_t;

  typedef enum logic {ST_IDLE, ST_SWEEP} sweep_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic incNow;
    logic incExpiry;
    logic loadTgt;
    logic checkEn;
  } age_strobe_t;
endpackage

// File: rtl/stamp_age_ctrl.sv
module stamp_age_ctrl
  import stamp_age_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickPin,
  input  logic                   cfgWrEn,
  input  logic [CFG_W-1:0]       cfgWrData,
  input  logic                   bumpNow,
  input  logic                   bumpExpiry,
  output logic [CFG_W-1:0]       cfgQ,
  output age_strobe_t            str,
  output logic [IDX_W-1:0]       sweepIdx,
  output logic                   busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic syncA, syncB, syncC;
  logic gateOn, pinTick, sweepReq, atLast, pend;
  sweep_state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= tickPin;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign gateOn   = cfgQ[GATE_BIT_A] & cfgQ[GATE_BIT_B];
  assign pinTick  = gateOn & syncB & ~syncC;
  assign sweepReq = pinTick | bumpExpiry;
  assign atLast   = (state == ST_SWEEP) && (sweepIdx == LAST);

  always_comb begin
    str.incNow    = pinTick | bumpNow;
    str.incExpiry = pinTick | bumpExpiry;
    str.loadTgt   = ((state == ST_IDLE) && sweepReq) || (atLast && (pend || sweepReq));
    str.checkEn   = (state == ST_SWEEP);
  end

  assign busy = (state == ST_SWEEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sweepIdx <= '0;
      pend     <= 1'b0;
      cfgQ     <= '0;
    end else begin
      if (cfgWrEn) cfgQ <= cfgWrData;
      unique case (state)
        ST_IDLE: begin
          if (sweepReq) begin
            state    <= ST_SWEEP;
            sweepIdx <= '0;
          end
        end
        ST_SWEEP: begin
          if (sweepIdx == LAST) begin
            if (pend || sweepReq) begin
              sweepIdx <= '0;
              pend     <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            sweepIdx <= sweepIdx + 1'b1;
            if (sweepReq) pend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a pin edge yields a single-cycle tick
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    pinTick |=> !pinTick);

  // R6: sweep index advances one slot per clock
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SWEEP && sweepIdx != LAST) |=>
      (state == ST_SWEEP && sweepIdx == $past(sweepIdx) + 1'b1));

  // R7: a pending tick restarts the sweep at slot 0
  assert_pend_rerun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (atLast && pend) |=> (state == ST_SWEEP && sweepIdx == '0));
endmodule

// File: rtl/stamp_age_dpath.sv
module stamp_age_dpath
  import stamp_age_pkg::*;
#(
  parameter int N     = 16,
  parameter int KEY_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  age_strobe_t       str,
  input  logic [IDX_W-1:0]  sweepIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [KEY_W-1:0]  rdKey,
  output stamp_t            rdStamp,
  output stamp_t            nowTime,
  output stamp_t            expiryTime
);
  stamp_t             expiryNext, tgtQ;
  logic [N-1:0]       validQ;
  logic [KEY_W-1:0]   keyQ   [N];
  stamp_t             stampQ [N];

  assign expiryNext = expiryTime + {{(STAMP_W-1){1'b0}}, str.incExpiry};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowTime    <= '0;
      expiryTime <= '0;
      tgtQ       <= '0;
    end else begin
      if (str.incNow)  nowTime <= nowTime + 1'b1;
      expiryTime <= expiryNext;
      if (str.loadTgt) tgtQ <= expiryNext;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic writeHit, purgeHit;
    assign writeHit = wrEn && (wrIdx == IDX_W'(i));
    assign purgeHit = str.checkEn && (sweepIdx == IDX_W'(i)) && (stampQ[i] == tgtQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        keyQ[i]   <= '0;
        stampQ[i] <= '0;
      end else if (writeHit) begin
        validQ[i] <= 1'b1;
        keyQ[i]   <= wrKey;
        stampQ[i] <= nowTime;
      end else if (purgeHit) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  assign rdValid = validQ[rdIdx];
  assign rdKey   = keyQ[rdIdx];
  assign rdStamp = stampQ[rdIdx];

  // R8: now counter only moves on its strobe
  assert_now_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !str.incNow |=> $stable(nowTime));

  // R10: now counter steps by one, wrapping modulo 256
  assert_now_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    str.incNow |=> nowTime == stamp_t'($past(nowTime) + 1'b1));

  // R2: a write leaves the slot valid with the now stamp
  assert_write_stamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (validQ[$past(wrIdx)] && stampQ[$past(wrIdx)] == $past(nowTime)));

  // R5: a matching slot is cleared by the sweep
  assert_purge_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (str.checkEn && validQ[sweepIdx] && stampQ[sweepIdx] == tgtQ &&
     !(wrEn && wrIdx == sweepIdx)) |=> !validQ[$past(sweepIdx)]);
endmodule

// File: rtl/stamp_age_purge.sv
module stamp_age_purge
  import stamp_age_pkg::*;
#(
  parameter int N     = 16,
  parameter int KEY_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickPin,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic              bumpNow,
  input  logic              bumpExpiry,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [KEY_W-1:0]  rdKey,
  output logic [7:0]        rdStamp,
  output logic [7:0]        cfgQ,
  output logic [7:0]        nowTime,
  output logic [7:0]        expiryTime,
  output logic              busy
);
  age_strobe_t       str;
  logic [IDX_W-1:0]  sweepIdx;

  stamp_age_ctrl #(.N(N), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickPin(tickPin),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .bumpNow(bumpNow), .bumpExpiry(bumpExpiry),
    .cfgQ(cfgQ), .str(str), .sweepIdx(sweepIdx), .busy(busy)
  );

  stamp_age_dpath #(.N(N), .KEY_W(KEY_W), .IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rstN(rstN), .str(str), .sweepIdx(sweepIdx),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrKey(wrKey), .rdIdx(rdIdx),
    .rdValid(rdValid), .rdKey(rdKey), .rdStamp(rdStamp),
    .nowTime(nowTime), .expiryTime(expiryTime)
  );
endmodule

// File: tb/stamp_age_purge_tb_top.sv
`timescale 1ns/1ps
module stamp_age_purge_tb_top;
  localparam int N     = 16;
  localparam int KEY_W = 16;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickPin = 1'b0, cfgWrEn = 1'b0, bumpNow = 1'b0, bumpExpiry = 1'b0, wrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [IDX_W-1:0] wrIdx = '0, rdIdx = '0;
  logic [KEY_W-1:0] wrKey = '0;
  logic rdValid, busy;
  logic [KEY_W-1:0] rdKey;
  logic [7:0] rdStamp, cfgQ, nowTime, expiryTime;

  always #10 clk = ~clk;

  stamp_age_purge #(.N(N), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rstN(rstN), .tickPin(tickPin), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .bumpNow(bumpNow), .bumpExpiry(bumpExpiry), .wrEn(wrEn), .wrIdx(wrIdx), .wrKey(wrKey),
    .rdIdx(rdIdx), .rdValid(rdValid), .rdKey(rdKey), .rdStamp(rdStamp), .cfgQ(cfgQ),
    .nowTime(nowTime), .expiryTime(expiryTime), .busy(busy)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  int mValid [N];
  int mKey   [N];
  int mStamp [N];
  int mNow = 0, mExp = 0;

  typedef struct { int idx; int vld; int key; int stamp; string req; } exp_t;
  exp_t sbQ[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelPurge(int tgt);
    for (int i = 0; i < N; i++) if (mValid[i] != 0 && mStamp[i] == tgt) mValid[i] = 0;
  endtask

  // driver side: push expected slot contents
  task automatic pushTable(string req);
    for (int i = 0; i < N; i++) begin
      exp_t e;
      e.idx = i; e.vld = mValid[i]; e.key = mKey[i]; e.stamp = mStamp[i]; e.req = req;
      sbQ.push_back(e);
    end
  endtask

  // monitor side: pop and compare against the read port
  task automatic monitorDrain();
    while (sbQ.size() > 0) begin
      exp_t e;
      e = sbQ.pop_front();
      @(negedge clk);
      rdIdx = IDX_W'(e.idx);
      #1;
      chk(e.req, $sformatf("slot%0d valid", e.idx), int'(rdValid), e.vld);
      if (e.vld != 0) begin
        chk(e.req, $sformatf("slot%0d key", e.idx), int'(rdKey), e.key);
        chk(e.req, $sformatf("slot%0d stamp", e.idx), int'(rdStamp), e.stamp);
      end
    end
  endtask

  task automatic writeSlot(int idx, int key);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrKey = KEY_W'(key);
    @(negedge clk);
    wrEn = 1'b0;
    mValid[idx] = 1; mKey[idx] = key; mStamp[idx] = mNow;
  endtask

  task automatic setCfg(int v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 8'(v);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseNow();
    @(negedge clk); bumpNow = 1'b1;
    @(negedge clk); bumpNow = 1'b0;
    mNow = (mNow + 1) % 256;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulseExpiry();
    @(negedge clk); bumpExpiry = 1'b1;
    @(negedge clk); bumpExpiry = 1'b0;
    mExp = (mExp + 1) % 256;
    waitIdle();
    modelPurge(mExp);
  endtask

  task automatic chkCounters(string req);
    chk(req, "nowTime", int'(nowTime), mNow);
    chk(req, "expiryTime", int'(expiryTime), mExp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mKey[i] = 0; mStamp[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkCounters("R1");
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "cfgQ", int'(cfgQ), 0);
    pushTable("R1");
    monitorDrain();

    // R2 / R8: stamping and now-only bumps
    for (int i = 0; i < 6; i++) writeSlot(i, 16'h1000 + i);
    pulseNow();
    writeSlot(6, 16'h2006); writeSlot(7, 16'h2007);
    pulseNow(); pulseNow();
    @(negedge clk);
    chk("R8", "busy after now bumps", int'(busy), 0);
    chkCounters("R8");
    writeSlot(8, 16'h3008); writeSlot(9, 16'h3009);
    pushTable("R2");
    monitorDrain();

    // R4: one enable bit alone does not pass the pin
    setCfg(8'h04);
    @(negedge clk); tickPin = 1'b1;
    repeat (6) @(negedge clk);
    tickPin = 1'b0;
    chkCounters("R4 bit2 only");
    chk("R4", "busy bit2 only", int'(busy), 0);
    setCfg(8'h08);
    @(negedge clk); tickPin = 1'b1;
    repeat (6) @(negedge clk);
    tickPin = 1'b0;
    chkCounters("R4 bit3 only");
    pushTable("R4");
    monitorDrain();

    // R3 / R5 / R6: gated pin tick, latency and sweep length
    setCfg(8'h0C);
    chk("R4", "cfgQ", int'(cfgQ), 8'h0C);
    repeat (3) @(negedge clk);
    tickPin = 1'b1;
    repeat (2) @(negedge clk);
    chkCounters("R3 before third edge");
    @(negedge clk);
    mNow = (mNow + 1) % 256; mExp = (mExp + 1) % 256;
    chkCounters("R3 after third edge");
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk("R6", "busy cycles", cnt, N);
    modelPurge(mExp);
    repeat (10) @(negedge clk);
    chkCounters("R3 pin held high");
    tickPin = 1'b0;
    pushTable("R5");
    monitorDrain();

    // R9: expiry-only bumps sweep the table
    pulseExpiry();
    chkCounters("R9");
    pulseExpiry();
    chkCounters("R9");
    pushTable("R9");
    monitorDrain();

    // R7: tick during a sweep gives a back-to-back second sweep
    writeSlot(11, 16'h400B);
    pulseNow();
    writeSlot(12, 16'h500C);
    @(negedge clk); tickPin = 1'b1;
    while (!busy) @(negedge clk);
    mNow = (mNow + 1) % 256; mExp = (mExp + 1) % 256;
    modelPurge(mExp);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 5) bumpExpiry = 1'b1;
      @(negedge clk);
      bumpExpiry = 1'b0;
    end
    tickPin = 1'b0;
    mExp = (mExp + 1) % 256;
    modelPurge(mExp);
    chk("R7", "busy cycles", cnt, 2 * N);
    chkCounters("R7");
    pushTable("R7");
    monitorDrain();

    // R10: wrap of both counters, slots stamped 0 expire at wrap
    while (mNow != 255) pulseNow();
    chkCounters("R10 now at 255");
    writeSlot(1, 16'h7001);
    pulseNow();
    chkCounters("R10 now wrap");
    while (mExp != 0) pulseExpiry();
    chkCounters("R10 expiry wrap");
    pushTable("R10");
    monitorDrain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule